// File: doc/BRIEF.md
# Read Data Realigner

This unit sits on the read path between the system bus and internal storage, and every read transfer goes through it, whether or not the transfer is aligned. A requester starts a transfer by giving a byte start address and a nonzero byte count. The bus side only accepts fetches at 8-byte-aligned addresses, so the unit clears the low three address bits and walks upward one 64-bit word at a time. The bus side of the handshake is a plain request/valid pair: the request and its address hold until a valid beat returns the data.

Returned words are shifted and merged so that the output stream starts on a word boundary. The first requested byte appears in lane 0, and the following bytes follow on without gaps. An output word takes the upper lanes of the previous fetch together with the lower lanes of the current fetch. The unit issues just enough fetches to cover the offset plus the count. When the requested bytes end inside the last fetched word, one drain cycle emits the final word from the holding register. The final output word carries a byte mask for the lanes that hold requested data. A transfer with a zero offset passes each fetched word straight to the output one cycle after it arrives.

Top module: `realign_rd`

## Requirements
- R1: Every fetch address presented while `fetch_req` is high has bits [2:0] equal to zero.
- R2: The first fetch address is the start address with bits [2:0] cleared, and each later fetch of the same transfer is 8 higher. A request holds its address until `fetch_vld` is seen.
- R3: A transfer with offset o (start address bits [2:0]) and count n issues exactly ceil((o+n)/8) fetches.
- R4: A transfer produces exactly ceil(n/8) output words. `out_last` is high on the final word and only on that word.
- R5: Output word k, lane j (bits 8j+7:8j) holds the byte at start address + 8k + j for every lane that the mask marks valid.
- R6: `out_mask` bit j marks lane j valid. Every word except the last has mask 0xFF. The last word has its lowest r bits set, where r = n mod 8, or all 8 bits when n mod 8 is 0.
- R7: When the offset is zero, each output word appears on the cycle right after the fetch beat that carries it, and no output appears at any other time.
- R8: A start pulse is ignored while the unit is busy, and also when the count is zero. The transfer in flight keeps its addresses and data.
- R9: After reset, `busy`, `fetch_req` and `out_vld` are low, and `fetch_req` is never high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer (taken only when idle and count nonzero) |
| start_addr | input | AW | Byte start address, may be unaligned |
| byte_cnt | input | CW | Number of bytes to read |
| busy | output | 1 | Transfer in progress |
| fetch_req | output | 1 | Fetch request toward the bus |
| fetch_addr | output | AW | 8-byte-aligned fetch address |
| fetch_vld | input | 1 | Fetch data beat returned |
| fetch_data | input | 64 | Returned word, lane 0 in bits 7:0 |
| out_vld | output | 1 | Packed output word valid |
| out_data | output | 64 | Packed output word |
| out_mask | output | 8 | Valid byte lanes of the output word |
| out_last | output | 1 | Final word of the transfer |

## Verification
The assertions assume that the bus side raises `fetch_vld` only while `fetch_req` is high, and that a beat answers the address shown in that same cycle. The bench responder follows that rule: it answers only an outstanding request, inserts a varying delay of zero to three cycles, and drops `fetch_vld` for a cycle after every beat. Start pulses are sent only with nonzero counts, except for the deliberate zero-count and busy-time pulses that test R8. These pulses are chosen so that a unit that took them would change the fetch addresses or the output stream that the scoreboard expects.

// File: rtl/realign_pkg.sv
package realign_pkg;

    localparam int LANES = 8;
    localparam int LW    = $clog2(LANES);
    localparam int DW    = LANES * 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DRAIN
    } rd_state_e;

    // One cycle worth of control from the sequencer to the datapath
    typedef struct packed {
        logic             cap;    // latch returned word into holding register
        logic             emit;   // produce an output word this cycle
        logic             drain;  // output comes from holding register only
        logic             last;   // final word of the transfer
        logic [LW-1:0]    off;    // lane offset of the first requested byte
        logic [LANES-1:0] mask;   // valid lanes of the emitted word
    } step_t;

    // Lanes below r valid; r == 0 means a full word
    function automatic logic [LANES-1:0] tail_mask(input logic [LW-1:0] r);
        logic [LANES-1:0] m;
        for (int i = 0; i < LANES; i++)
            m[i] = (r == '0) || (i < int'(r));
        return m;
    endfunction

    // Upper lanes of hold followed by lower lanes of cur, shifted by off
    function automatic logic [DW-1:0] pack_word(input logic [DW-1:0] cur,
                                                input logic [DW-1:0] hold,
                                                input logic [LW-1:0] off);
        logic [2*DW-1:0] both;
        logic [2*DW-1:0] sh;
        if (off == '0)
            return cur;
        both = {cur, hold};
        sh   = both >> {off, 3'b000};
        return sh[DW-1:0];
    endfunction

endpackage

// File: rtl/realign_ctrl.sv
module realign_ctrl
    import realign_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    input  logic [CW-1:0] byte_cnt,
    input  logic          fetch_vld,
    output logic          fetch_req,
    output logic [AW-1:0] fetch_addr,
    output logic          busy,
    output step_t         step
);

    localparam int NW = CW + 1;

    rd_state_e     state_q;
    logic [AW-1:0] addr_q;
    logic [LW-1:0] off_q;
    logic [LW-1:0] rem_q;
    logic [NW-1:0] fleft_q;
    logic [NW-1:0] wleft_q;
    logic          first_q;

    logic          take;
    logic          emit_f;
    logic          emit_d;
    logic [NW-1:0] span;
    logic [NW-1:0] wleft_after;

    assign take   = (state_q == ST_FETCH) && fetch_vld;
    assign emit_f = take && ((off_q == '0) || !first_q);
    assign emit_d = (state_q == ST_DRAIN);
    assign span   = {1'b0, byte_cnt} + NW'(start_addr[LW-1:0]) + NW'(LANES - 1);
    assign wleft_after = wleft_q - NW'(emit_f);

    always_comb begin
        step.cap   = take;
        step.emit  = emit_f || emit_d;
        step.drain = emit_d;
        step.last  = (emit_f || emit_d) && (wleft_q == NW'(1));
        step.off   = off_q;
        step.mask  = step.last ? tail_mask(rem_q) : '1;
    end

    assign fetch_req  = (state_q == ST_FETCH);
    assign fetch_addr = addr_q;
    assign busy       = (state_q != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            off_q   <= '0;
            rem_q   <= '0;
            fleft_q <= '0;
            wleft_q <= '0;
            first_q <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start && (byte_cnt != '0)) begin
                        addr_q  <= {start_addr[AW-1:LW], {LW{1'b0}}};
                        off_q   <= start_addr[LW-1:0];
                        rem_q   <= byte_cnt[LW-1:0];
                        fleft_q <= span >> LW;
                        wleft_q <= ({1'b0, byte_cnt} + NW'(LANES - 1)) >> LW;
                        first_q <= 1'b1;
                        state_q <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (take) begin
                        addr_q  <= addr_q + AW'(LANES);
                        fleft_q <= fleft_q - NW'(1);
                        wleft_q <= wleft_after;
                        first_q <= 1'b0;
                        if (fleft_q == NW'(1))
                            state_q <= (wleft_after != '0) ? ST_DRAIN : ST_IDLE;
                    end
                end
                ST_DRAIN: begin
                    wleft_q <= wleft_q - NW'(1);
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/realign_merge.sv
module realign_merge
    import realign_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [DW-1:0]    fetch_data,
    input  step_t            step,
    output logic             out_vld,
    output logic [DW-1:0]    out_data,
    output logic [LANES-1:0] out_mask,
    output logic             out_last
);

    logic [DW-1:0] hold_q;
    logic [DW-1:0] cur;

    assign cur = step.drain ? '0 : fetch_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q   <= '0;
            out_vld  <= 1'b0;
            out_data <= '0;
            out_mask <= '0;
            out_last <= 1'b0;
        end else begin
            if (step.cap)
                hold_q <= fetch_data;
            out_vld  <= step.emit;
            out_last <= step.emit && step.last;
            if (step.emit) begin
                out_data <= pack_word(cur, hold_q, step.off);
                out_mask <= step.mask;
            end
        end
    end

endmodule

// File: rtl/realign_rd.sv
module realign_rd
    import realign_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [AW-1:0]    start_addr,
    input  logic [CW-1:0]    byte_cnt,
    output logic             busy,
    output logic             fetch_req,
    output logic [AW-1:0]    fetch_addr,
    input  logic             fetch_vld,
    input  logic [DW-1:0]    fetch_data,
    output logic             out_vld,
    output logic [DW-1:0]    out_data,
    output logic [LANES-1:0] out_mask,
    output logic             out_last
);

    step_t step;

    realign_ctrl #(.AW(AW), .CW(CW)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .start_addr (start_addr),
        .byte_cnt   (byte_cnt),
        .fetch_vld  (fetch_vld),
        .fetch_req  (fetch_req),
        .fetch_addr (fetch_addr),
        .busy       (busy),
        .step       (step)
    );

    realign_merge u_merge (
        .clk        (clk),
        .rst        (rst),
        .fetch_data (fetch_data),
        .step       (step),
        .out_vld    (out_vld),
        .out_data   (out_data),
        .out_mask   (out_mask),
        .out_last   (out_last)
    );

endmodule

// File: rtl/realign_rd_chk.sv
module realign_rd_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          busy,
    input logic          fetch_req,
    input logic [AW-1:0] fetch_addr,
    input logic          fetch_vld,
    input logic          out_vld,
    input logic [7:0]    out_mask,
    input logic          out_last
);

    // R1
    fetch_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        fetch_req |-> (fetch_addr[2:0] == 3'b000));

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (fetch_req && !fetch_vld) |=> (fetch_req && $stable(fetch_addr)));

    // R2
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (fetch_req && fetch_vld) |=> (!fetch_req || (fetch_addr == $past(fetch_addr) + AW'(8))));

    // R4
    last_vld_chk: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_vld);

    // R6
    mask_full_chk: assert property (@(posedge clk) disable iff (rst)
        (out_vld && !out_last) |-> (out_mask == 8'hFF));

    // R6
    mask_shape_chk: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> (out_mask[0] && (((out_mask + 8'd1) & out_mask) == 8'd0)));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !fetch_req);

endmodule

bind realign_rd realign_rd_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .fetch_req  (fetch_req),
    .fetch_addr (fetch_addr),
    .fetch_vld  (fetch_vld),
    .out_vld    (out_vld),
    .out_mask   (out_mask),
    .out_last   (out_last)
);

// File: tb/realign_rd_tb.sv
module realign_rd_tb;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int CW = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [CW-1:0] byte_cnt = '0;
    logic          busy;
    logic          fetch_req;
    logic [AW-1:0] fetch_addr;
    logic          fetch_vld = 1'b0;
    logic [63:0]   fetch_data = '0;
    logic          out_vld;
    logic [63:0]   out_data;
    logic [7:0]    out_mask;
    logic          out_last;

    int errors = 0;
    int checks = 0;
    int fetch_seen = 0;
    bit off0_mode = 1'b0;
    bit active = 1'b0;
    logic [7:0] lfsr = 8'hA5;
    int wait_cnt = 0;

    logic [AW-1:0] exp_addr[$];
    logic [63:0]   exp_data[$];
    logic [7:0]    exp_mask[$];
    logic          exp_last[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    realign_rd #(.AW(AW), .CW(CW)) u_dut (
        .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
        .byte_cnt(byte_cnt), .busy(busy), .fetch_req(fetch_req),
        .fetch_addr(fetch_addr), .fetch_vld(fetch_vld), .fetch_data(fetch_data),
        .out_vld(out_vld), .out_data(out_data), .out_mask(out_mask),
        .out_last(out_last)
    );

    function automatic logic [7:0] mem_byte(input logic [AW-1:0] a);
        return 8'((a * 13) ^ (a >> 5) ^ 32'h5A);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] lane_bits(input logic [7:0] m);
        logic [63:0] r;
        for (int j = 0; j < 8; j++) r[j*8 +: 8] = {8{m[j]}};
        return r;
    endfunction

    // Monitor and bus responder, both on the falling edge
    always @(negedge clk) begin
        if (!rst) begin
            if (off0_mode && active)
                // R7: zero offset gives output exactly one cycle after each beat
                chk(out_vld == fetch_vld, "R7", "pass-through latency", 64'(out_vld), 64'(fetch_vld));
            if (out_vld) begin
                if (exp_data.size() == 0) begin
                    chk(1'b0, "R4", "unexpected extra output word", out_data, 64'h0);
                end else begin
                    logic [63:0] ed;
                    logic [7:0]  em;
                    logic        el;
                    ed = exp_data.pop_front();
                    em = exp_mask.pop_front();
                    el = exp_last.pop_front();
                    chk(out_mask == em, "R6", "byte mask", 64'(out_mask), 64'(em));
                    chk(out_last == el, "R4", "last flag", 64'(out_last), 64'(el));
                    chk((out_data & lane_bits(em)) == ed, "R5", "packed data", out_data & lane_bits(em), ed);
                end
            end
            if (fetch_vld) begin
                fetch_vld = 1'b0;
            end else if (fetch_req) begin
                if (wait_cnt == 0) begin
                    logic [AW-1:0] ea;
                    ea = (exp_addr.size() != 0) ? exp_addr.pop_front() : '1;
                    // R1 R2: aligned, starting at cleared start address, stepping by 8
                    chk(fetch_addr == ea, "R2", "fetch address", 64'(fetch_addr), 64'(ea));
                    for (int i = 0; i < 8; i++)
                        fetch_data[i*8 +: 8] = mem_byte(fetch_addr + AW'(i));
                    fetch_vld = 1'b1;
                    fetch_seen++;
                    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                    wait_cnt = int'(lfsr[1:0]);
                end else begin
                    wait_cnt--;
                end
            end
        end
    end

    task automatic run_xfer(input logic [AW-1:0] a, input int n, input bit poke);
        int o, nf, nw;
        o  = int'(a[2:0]);
        nf = (o + n + 7) / 8;
        nw = (n + 7) / 8;
        for (int i = 0; i < nf; i++)
            exp_addr.push_back({a[AW-1:3], 3'b000} + AW'(8 * i));
        for (int k = 0; k < nw; k++) begin
            logic [63:0] d;
            logic [7:0]  m;
            d = '0;
            m = '0;
            for (int j = 0; j < 8; j++) begin
                if (8 * k + j < n) begin
                    d[j*8 +: 8] = mem_byte(a + AW'(8 * k + j));
                    m[j] = 1'b1;
                end
            end
            exp_data.push_back(d);
            exp_mask.push_back(m);
            exp_last.push_back(k == nw - 1);
        end
        fetch_seen = 0;
        off0_mode  = (o == 0);
        @(negedge clk);
        start = 1'b1; start_addr = a; byte_cnt = CW'(n);
        active = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (2) @(negedge clk);
            chk(busy == 1'b1, "R8", "busy before stray start", 64'(busy), 64'h1);
            start = 1'b1; start_addr = a + AW'(333); byte_cnt = CW'(7);
            @(negedge clk);
            start = 1'b0;
        end
        for (int t = 0; t < 3000; t++) begin
            if (!busy && exp_data.size() == 0 && exp_addr.size() == 0) break;
            @(negedge clk);
        end
        @(negedge clk);
        active = 1'b0;
        off0_mode = 1'b0;
        // R3: number of fetches
        chk(fetch_seen == nf, "R3", "fetch count", 64'(fetch_seen), 64'(nf));
        // R4: all words delivered
        chk(exp_data.size() == 0, "R4", "words left undelivered", 64'(exp_data.size()), 64'h0);
        chk(busy == 1'b0, "R8", "idle after transfer", 64'(busy), 64'h0);
        exp_addr.delete();
        exp_data.delete();
        exp_mask.delete();
        exp_last.delete();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R9: reset state
        chk(busy == 1'b0, "R9", "busy after reset", 64'(busy), 64'h0);
        chk(fetch_req == 1'b0, "R9", "fetch_req after reset", 64'(fetch_req), 64'h0);
        chk(out_vld == 1'b0, "R9", "out_vld after reset", 64'(out_vld), 64'h0);

        // R8: zero count start is ignored
        @(negedge clk);
        start = 1'b1; start_addr = 32'h40; byte_cnt = '0;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b0, "R8", "zero-count start", 64'(busy), 64'h0);
        chk(fetch_req == 1'b0, "R8", "zero-count fetch", 64'(fetch_req), 64'h0);

        run_xfer(32'h0000_0000, 16, 1'b0);   // aligned, R7
        run_xfer(32'h0000_0100, 3, 1'b0);    // aligned, short tail
        run_xfer(32'h0000_0203, 5, 1'b0);    // ends in first word: drain
        run_xfer(32'h0000_0303, 6, 1'b0);    // crosses into next word
        run_xfer(32'h0000_0405, 20, 1'b0);
        run_xfer(32'h0000_0507, 1, 1'b0);    // single byte at lane 7
        run_xfer(32'h0000_0601, 8, 1'b0);
        run_xfer(32'h0000_0706, 64, 1'b0);
        run_xfer(32'h0000_0902, 9, 1'b0);
        run_xfer(32'h0000_0A04, 100, 1'b1);  // R8 stray start while busy
        run_xfer(32'h0000_0B00, 40, 1'b1);   // R8 and R7 together
        run_xfer(32'h0000_0FFF, 17, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule